// File: doc/BRIEF.md
# Pipeline Operand Forwarding Unit

This block selects where each ALU source operand of the instruction sitting in the execute stage of a five-stage in-order pipeline comes from. The register file may still hold a stale copy of a register that an older instruction in the memory or writeback stage is about to update. The block compares each source register number with the destination of the two older instructions. It then routes the freshest available value to the ALU input.

Every operand multiplexer has four inputs. One is the register-file read. The other three are bypass paths: the ALU result held after execute (EX/MEM latch), the ALU result held after memory (MEM/WB latch), and the memory read data held after memory (MEM/WB latch). A load's result only exists once memory has returned it, so it can reach the ALU through the memory-data path alone.

The selection is purely combinational. For each operand the block outputs a 2-bit select code and the chosen value. Stall insertion for the load-use case belongs to a separate hazard unit.

Top module: `operand_forward`

## Requirements
- R1: When no older stage matches a source register, that operand's select is 00 and its value is the register-file read.
- R2: When the EX/MEM entry has write-enable set, is not a load, and its destination equals a nonzero source, the select is 01 and the value is the EX/MEM ALU result.
- R3: When only the MEM/WB entry matches a nonzero source with write-enable set and it is not a load, the select is 10 and the value is the MEM/WB ALU result.
- R4: When only the MEM/WB entry matches a nonzero source with write-enable set and it is a load, the select is 11 and the value is the MEM/WB memory read data.
- R5: When EX/MEM (non-load) and MEM/WB both match the same source, the EX/MEM path wins (select 01).
- R6: A source register number of 0 always gives select 00 and the register-file value, whatever the older stages hold.
- R7: A stage whose write-enable is clear never matches, even if its destination equals the source.
- R8: An EX/MEM entry flagged as a load is never chosen. That operand falls through to the MEM/WB rules, or to the register file.
- R9: Each operand is resolved independently, so the two operands may take different paths in the same cycle.
- R10: The sequence ADD R1,R2,R3; SUB R4,R5,R1; AND R6,R1,R7 issued back to back yields the same results as sequential execution. SUB takes R1 via select 01 and AND takes R1 via select 10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| exSrcReg | input | NUM_SRC x REG_ADDR_W | Source register numbers of the instruction in execute |
| rfData | input | NUM_SRC x DATA_W | Register-file read values for each source |
| exMemDest | input | REG_ADDR_W | Destination register in the EX/MEM latch |
| exMemWe | input | 1 | Register write-enable in the EX/MEM latch |
| exMemIsLoad | input | 1 | EX/MEM latch holds a load |
| exMemAlu | input | DATA_W | ALU result held in EX/MEM |
| memWbDest | input | REG_ADDR_W | Destination register in the MEM/WB latch |
| memWbWe | input | 1 | Register write-enable in the MEM/WB latch |
| memWbIsLoad | input | 1 | MEM/WB latch holds a load |
| memWbAlu | input | DATA_W | ALU result held in MEM/WB |
| memWbLoad | input | DATA_W | Memory read data held in MEM/WB |
| opSel | output | NUM_SRC x 2 | Per-operand path code: 00 reg file, 01 EX/MEM ALU, 10 MEM/WB ALU, 11 MEM/WB load |
| opVal | output | NUM_SRC x DATA_W | Per-operand selected value |

## Verification
The bench builds the block with REG_ADDR_W = 3, DATA_W = 16 and NUM_SRC = 2. With eight registers, every combination of source number, EX/MEM destination, MEM/WB destination and the four enable/load flags can be swept. Register 0, exact matches, near misses, the disabled-write case and the double-match priority case all come up with every flag setting. The second operand's source is offset from the first, so the two operands often take different paths in the same cycle. A directed run of the ADD/SUB/AND sequence compares the results built from the forwarded operands with a sequential register model.

// File: rtl/fwd_pkg.sv
package fwd_pkg;

  typedef enum logic [1:0] {
    SEL_RF         = 2'b00,
    SEL_EXMEM_ALU  = 2'b01,
    SEL_MEMWB_ALU  = 2'b10,
    SEL_MEMWB_LOAD = 2'b11
  } fwd_sel_e;

  // strobes from control to datapath, at most one set per operand
  typedef struct packed {
    logic exHit;
    logic wbAluHit;
    logic wbLoadHit;
  } fwd_strobe_t;

endpackage

// File: rtl/fwd_ctrl.sv
module fwd_ctrl
  import fwd_pkg::*;
#(
  parameter int REG_ADDR_W = 5,
  parameter int NUM_SRC    = 2
) (
  input  logic [NUM_SRC-1:0][REG_ADDR_W-1:0] exSrcReg,
  input  logic [REG_ADDR_W-1:0]              exMemDest,
  input  logic                               exMemWe,
  input  logic                               exMemIsLoad,
  input  logic [REG_ADDR_W-1:0]              memWbDest,
  input  logic                               memWbWe,
  input  logic                               memWbIsLoad,
  output fwd_strobe_t [NUM_SRC-1:0]          strobe,
  output logic [NUM_SRC-1:0][1:0]            opSel
);

  localparam logic [REG_ADDR_W-1:0] ZERO_REG = '0;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    logic srcLive;
    logic exMatch;
    logic wbMatch;
    fwd_sel_e selCode;

    always_comb begin
      srcLive = exSrcReg[i] != ZERO_REG;
      // a load in EX/MEM has no data yet; it is skipped here
      exMatch = srcLive && exMemWe && !exMemIsLoad && (exMemDest == exSrcReg[i]);
      wbMatch = srcLive && memWbWe && (memWbDest == exSrcReg[i]);

      strobe[i].exHit     = exMatch;
      strobe[i].wbAluHit  = !exMatch && wbMatch && !memWbIsLoad;
      strobe[i].wbLoadHit = !exMatch && wbMatch && memWbIsLoad;

      if (strobe[i].exHit)          selCode = SEL_EXMEM_ALU;
      else if (strobe[i].wbAluHit)  selCode = SEL_MEMWB_ALU;
      else if (strobe[i].wbLoadHit) selCode = SEL_MEMWB_LOAD;
      else                          selCode = SEL_RF;

      opSel[i] = selCode;
    end
  end

endmodule

// File: rtl/fwd_datapath.sv
module fwd_datapath
  import fwd_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int NUM_SRC = 2
) (
  input  fwd_strobe_t [NUM_SRC-1:0]      strobe,
  input  logic [NUM_SRC-1:0][DATA_W-1:0] rfData,
  input  logic [DATA_W-1:0]              exMemAlu,
  input  logic [DATA_W-1:0]              memWbAlu,
  input  logic [DATA_W-1:0]              memWbLoad,
  output logic [NUM_SRC-1:0][DATA_W-1:0] opVal
);

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_mux
    // AND-OR mux: strobes are mutually exclusive
    always_comb begin
      opVal[i] = ({DATA_W{strobe[i].exHit}}     & exMemAlu)
               | ({DATA_W{strobe[i].wbAluHit}}  & memWbAlu)
               | ({DATA_W{strobe[i].wbLoadHit}} & memWbLoad)
               | ({DATA_W{!(strobe[i].exHit || strobe[i].wbAluHit || strobe[i].wbLoadHit)}}
                  & rfData[i]);
    end
  end

endmodule

// File: rtl/operand_forward.sv
module operand_forward
  import fwd_pkg::*;
#(
  parameter int REG_ADDR_W = 5,
  parameter int DATA_W     = 32,
  parameter int NUM_SRC    = 2
) (
  input  logic [NUM_SRC-1:0][REG_ADDR_W-1:0] exSrcReg,
  input  logic [NUM_SRC-1:0][DATA_W-1:0]     rfData,
  input  logic [REG_ADDR_W-1:0]              exMemDest,
  input  logic                               exMemWe,
  input  logic                               exMemIsLoad,
  input  logic [DATA_W-1:0]                  exMemAlu,
  input  logic [REG_ADDR_W-1:0]              memWbDest,
  input  logic                               memWbWe,
  input  logic                               memWbIsLoad,
  input  logic [DATA_W-1:0]                  memWbAlu,
  input  logic [DATA_W-1:0]                  memWbLoad,
  output logic [NUM_SRC-1:0][1:0]            opSel,
  output logic [NUM_SRC-1:0][DATA_W-1:0]     opVal
);

  fwd_strobe_t [NUM_SRC-1:0] strobe;

  fwd_ctrl #(
    .REG_ADDR_W(REG_ADDR_W),
    .NUM_SRC   (NUM_SRC)
  ) u_ctrl (
    .exSrcReg   (exSrcReg),
    .exMemDest  (exMemDest),
    .exMemWe    (exMemWe),
    .exMemIsLoad(exMemIsLoad),
    .memWbDest  (memWbDest),
    .memWbWe    (memWbWe),
    .memWbIsLoad(memWbIsLoad),
    .strobe     (strobe),
    .opSel      (opSel)
  );

  fwd_datapath #(
    .DATA_W (DATA_W),
    .NUM_SRC(NUM_SRC)
  ) u_dp (
    .strobe   (strobe),
    .rfData   (rfData),
    .exMemAlu (exMemAlu),
    .memWbAlu (memWbAlu),
    .memWbLoad(memWbLoad),
    .opVal    (opVal)
  );

endmodule

// File: rtl/fwd_checker.sv
module fwd_checker #(
  parameter int REG_ADDR_W = 5,
  parameter int DATA_W     = 32,
  parameter int NUM_SRC    = 2
) (
  input logic [NUM_SRC-1:0][REG_ADDR_W-1:0] exSrcReg,
  input logic [NUM_SRC-1:0][DATA_W-1:0]     rfData,
  input logic [REG_ADDR_W-1:0]              exMemDest,
  input logic                               exMemWe,
  input logic                               exMemIsLoad,
  input logic [DATA_W-1:0]                  exMemAlu,
  input logic [REG_ADDR_W-1:0]              memWbDest,
  input logic                               memWbWe,
  input logic                               memWbIsLoad,
  input logic [DATA_W-1:0]                  memWbAlu,
  input logic [DATA_W-1:0]                  memWbLoad,
  input logic [NUM_SRC-1:0][1:0]            opSel,
  input logic [NUM_SRC-1:0][DATA_W-1:0]     opVal
);

  always_comb begin
    for (int i = 0; i < NUM_SRC; i++) begin
      if (!$isunknown({exSrcReg, exMemDest, exMemWe, exMemIsLoad, memWbDest, memWbWe,
                       memWbIsLoad, opSel})) begin
        assert_zero_src_R6: assert (exSrcReg[i] != '0 || opSel[i] == 2'b00)
          else $error("register 0 forwarded on operand %0d", i);
        assert_ex_priority_R5: assert (!(exMemWe && !exMemIsLoad && exSrcReg[i] != '0 &&
                                         exMemDest == exSrcReg[i]) || opSel[i] == 2'b01)
          else $error("EX/MEM match not selected on operand %0d", i);
        assert_load_path_R4: assert (opSel[i] != 2'b11 ||
                                     (memWbWe && memWbIsLoad && memWbDest == exSrcReg[i]))
          else $error("load path chosen without MEM/WB load match on operand %0d", i);
        assert_write_enable_R7: assert (opSel[i] == 2'b00 ||
                                        (opSel[i] == 2'b01 ? exMemWe : memWbWe))
          else $error("disabled stage forwarded on operand %0d", i);
        assert_ex_load_skip_R8: assert (!(opSel[i] == 2'b01 && exMemIsLoad))
          else $error("EX/MEM load selected on operand %0d", i);
      end
      if (!$isunknown({opSel, opVal, exMemAlu, memWbAlu, memWbLoad, rfData})) begin
        assert_value_path_R2: assert (opVal[i] == (opSel[i] == 2'b01 ? exMemAlu :
                                                   opSel[i] == 2'b10 ? memWbAlu :
                                                   opSel[i] == 2'b11 ? memWbLoad : rfData[i]))
          else $error("value disagrees with select on operand %0d", i);
      end
    end
  end

endmodule

bind operand_forward fwd_checker #(
  .REG_ADDR_W(REG_ADDR_W),
  .DATA_W    (DATA_W),
  .NUM_SRC   (NUM_SRC)
) u_chk (.*);

// File: tb/operand_forward_tb.sv
module operand_forward_tb;

  localparam int AW = 3;
  localparam int DW = 16;
  localparam int NS = 2;
  localparam int NREG = 1 << AW;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic [NS-1:0][AW-1:0] exSrcReg;
  logic [NS-1:0][DW-1:0] rfData;
  logic [AW-1:0] exMemDest, memWbDest;
  logic exMemWe, exMemIsLoad, memWbWe, memWbIsLoad;
  logic [DW-1:0] exMemAlu, memWbAlu, memWbLoad;
  logic [NS-1:0][1:0] opSel;
  logic [NS-1:0][DW-1:0] opVal;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  operand_forward #(.REG_ADDR_W(AW), .DATA_W(DW), .NUM_SRC(NS)) u_dut (.*);

  task automatic check(input string req, input int actual, input int expected);
    checks++;
    if (actual != expected) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, actual, expected);
    end
  endtask

  // expected select from the requirement text
  function automatic int expSel(input int src);
    bit exOk, wbOk;
    if (src == 0) return 0;
    exOk = exMemWe && !exMemIsLoad && (int'(exMemDest) == src);
    wbOk = memWbWe && (int'(memWbDest) == src);
    if (exOk) return 1;
    if (wbOk) return memWbIsLoad ? 3 : 2;
    return 0;
  endfunction

  function automatic string tagFor(input int src, input int sel);
    if (src == 0) return "R6";
    if (sel == 1 && memWbWe && int'(memWbDest) == src) return "R5";
    if (sel == 1) return "R2";
    if (sel == 2) return "R3";
    if (sel == 3) return "R4";
    if (exMemWe && exMemIsLoad && int'(exMemDest) == src) return "R8";
    if (int'(exMemDest) == src || int'(memWbDest) == src) return "R7";
    return "R1";
  endfunction

  function automatic int expVal(input int op, input int sel);
    case (sel)
      1: return int'(exMemAlu);
      2: return int'(memWbAlu);
      3: return int'(memWbLoad);
      default: return int'(rfData[op]);
    endcase
  endfunction

  task automatic checkOps(input string extra);
    for (int op = 0; op < NS; op++) begin
      int src = int'(exSrcReg[op]);
      int es = expSel(src);
      string t = tagFor(src, es);
      check({t, extra, " sel"}, int'(opSel[op]), es);
      check({t, extra, " val"}, int'(opVal[op]), expVal(op, es));
    end
  endtask

  task automatic idleInputs();
    exSrcReg = '0; rfData = '0;
    exMemDest = '0; exMemWe = 0; exMemIsLoad = 0; exMemAlu = 16'h3333;
    memWbDest = '0; memWbWe = 0; memWbIsLoad = 0; memWbAlu = 16'h4444; memWbLoad = 16'h5555;
  endtask

  // sequential reference registers for the ADD/SUB/AND run
  logic [DW-1:0] regs [NREG];
  logic [DW-1:0] addRes, subRes, andRes;

  initial begin
    idleInputs();
    exSrcReg[0] = 3'd2; exSrcReg[1] = 3'd5;
    rfData[0] = 16'h1002; rfData[1] = 16'h2005;
    @(negedge clk);
    // idle pipeline: both operands from register file
    check("R1 idle op0 sel", int'(opSel[0]), 0);
    check("R1 idle op1 val", int'(opVal[1]), 16'h2005);

    // R9: operands take different paths together
    @(posedge clk);
    exSrcReg[0] = 3'd3; exSrcReg[1] = 3'd6;
    exMemDest = 3'd3; exMemWe = 1;
    memWbDest = 3'd6; memWbWe = 1; memWbIsLoad = 1;
    @(negedge clk);
    check("R9 op0 sel", int'(opSel[0]), 1);
    check("R9 op1 sel", int'(opSel[1]), 3);
    check("R9 op1 val", int'(opVal[1]), 16'h5555);

    // exhaustive sweep
    for (int s = 0; s < NREG; s++)
      for (int ed = 0; ed < NREG; ed++)
        for (int wd = 0; wd < NREG; wd++)
          for (int f = 0; f < 16; f++) begin
            @(posedge clk);
            exSrcReg[0] = AW'(s);
            exSrcReg[1] = AW'((s + 5) % NREG);
            rfData[0] = 16'h1000 | 16'(s);
            rfData[1] = 16'h2000 | 16'((s + 5) % NREG);
            exMemDest = AW'(ed); memWbDest = AW'(wd);
            exMemWe = f[0]; exMemIsLoad = f[1]; memWbWe = f[2]; memWbIsLoad = f[3];
            exMemAlu = 16'h3000 | 16'(f); memWbAlu = 16'h4000 | 16'(f);
            memWbLoad = 16'h5000 | 16'(f);
            @(negedge clk);
            checkOps(" sweep");
          end

    // R10: ADD R1,R2,R3 ; SUB R4,R5,R1 ; AND R6,R1,R7
    for (int r = 0; r < NREG; r++) regs[r] = (r == 0) ? '0 : DW'(16'h0101 * r + 16'h0030);
    idleInputs();
    @(posedge clk);  // ADD in execute, older stages idle
    exSrcReg[0] = 3'd2; exSrcReg[1] = 3'd3;
    rfData[0] = regs[2]; rfData[1] = regs[3];
    @(negedge clk);
    addRes = opVal[0] + opVal[1];
    @(posedge clk);  // SUB in execute, ADD in EX/MEM
    exSrcReg[0] = 3'd5; exSrcReg[1] = 3'd1;
    rfData[0] = regs[5]; rfData[1] = regs[1];
    exMemDest = 3'd1; exMemWe = 1; exMemIsLoad = 0; exMemAlu = addRes;
    @(negedge clk);
    check("R10 SUB takes R1 from EX/MEM", int'(opSel[1]), 1);
    subRes = opVal[0] - opVal[1];
    @(posedge clk);  // AND in execute, SUB in EX/MEM, ADD in MEM/WB
    exSrcReg[0] = 3'd1; exSrcReg[1] = 3'd7;
    rfData[0] = regs[1]; rfData[1] = regs[7];
    exMemDest = 3'd4; exMemAlu = subRes;
    memWbDest = 3'd1; memWbWe = 1; memWbIsLoad = 0; memWbAlu = addRes;
    @(negedge clk);
    check("R10 AND takes R1 from MEM/WB", int'(opSel[0]), 2);
    andRes = opVal[0] & opVal[1];
    // sequential reference
    regs[1] = regs[2] + regs[3];
    regs[4] = regs[5] - regs[1];
    regs[6] = regs[1] & regs[7];
    check("R10 ADD result", int'(addRes), int'(regs[1]));
    check("R10 SUB result", int'(subRes), int'(regs[4]));
    check("R10 AND result", int'(andRes), int'(regs[6]));

    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule